// File: doc/BRIEF.md
# Host Bus Register Interface

This block is the slave side of a display controller's CPU bus. A host selects it with a chip select and moves data with a read strobe or with one of two byte-lane write strobes. Each access holds the host through a wait signal for a fixed number of clock cycles before it completes. The pad for that wait signal is enabled only while the block is selected. Behind the bus sits a register array of 64 words of 16 bits. A small command FIFO is filled by an external DMA controller through a request and acknowledge handshake.

Two straps are captured while reset is held. The first chooses a 16-bit or an 8-bit data bus. The second chooses how registers are reached. In the flat layout every register has its own address. In the window layout, a pointer word and a data-port word give access to the whole array, and the pointer steps forward on its own after each data-port access.

An interrupt is raised when the enabled FIFO status becomes true. Any completed register access clears it. The interrupt leaves the block in two forms: an enable for an open-drain pad, and an active-low output that is driven in both directions.

Top module: `hostbus_regif`

## Requirements
- R1: While `sel_i` is low, `wait_oe_o` is 0, so the wait pad is high impedance.
- R2: While `sel_i` is high and no strobe is active, `wait_oe_o` is 1 and `wait_o` is 1.
- R3: When a selected access starts, `wait_o` goes low for exactly ACC_LAT cycles. It then stays high until the strobes are removed. Each access takes effect exactly once.
- R4: In 16-bit flat mode, the word index is `addr_i[6:1]`. `wr_hi_i` writes bits 15:8 and `wr_lo_i` writes bits 7:0. A read returns the whole word.
- R5: In 8-bit mode, data travels on bits 7:0 of the bus. `addr_i[0]`=1 selects the upper byte of the word and 0 selects the lower byte. Either write strobe writes the selected byte, and bits 15:8 of a read are 0.
- R6: In window mode, `addr_i[3:1]`=0 is the pointer and `addr_i[3:1]`=1 is the data port for register[pointer]. Other window words read as 0 and ignore writes.
- R7: In window mode, the pointer increments after each data-port access. In 8-bit mode it increments only after an access to the upper byte.
- R8: After reset, register 0 holds CTRL_RST (16'h0C01), every other register holds 0, and the pointer is 0.
- R9: The interrupt (`irq_od_oe_o`=1) is set when (status & enable) changes from zero to nonzero. Status bit 0 means the FIFO is empty and bit 1 means it is full. The enable is bits 1:0 of register 1.
- R10: Any completed register access clears the interrupt. `irq_pp_n_o` always equals the inverse of `irq_od_oe_o`.
- R11: With `sel_i` low, `dma_ack_i` together with a write strobe pushes `wdata_i` into the FIFO, and `dma_req_o` is low in the next cycle. `dma_req_o` is high afterwards only while the FIFO has space. A push into a full FIFO is ignored.
- R12: The straps are sampled only while `rst` is high. Changes after reset release have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| width16_strap_i | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| indirect_strap_i | input | 1 | 1 = window layout, 0 = flat layout |
| sel_i | input | 1 | Register chip select, active high |
| rd_i | input | 1 | Read strobe |
| wr_hi_i | input | 1 | Upper-lane write strobe |
| wr_lo_i | input | 1 | Lower-lane write strobe |
| addr_i | input | 7 | Byte address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid one cycle after wait returns high |
| wait_o | output | 1 | Wait level, active low |
| wait_oe_o | output | 1 | Wait pad output enable |
| irq_od_oe_o | output | 1 | Open-drain interrupt pad pull-down enable |
| irq_pp_n_o | output | 1 | Push-pull interrupt, active low |
| dma_req_o | output | 1 | Command data request |
| dma_ack_i | input | 1 | Command data acknowledge |
| cmd_pop_i | input | 1 | Consumer takes the FIFO head |
| cmd_data_o | output | 16 | FIFO head word |
| cmd_valid_o | output | 1 | FIFO holds data |

## Verification
Register traffic is run under three strap combinations: 16-bit flat, 8-bit window and 16-bit window. In each one, a value that is correct under one decoding rule is wrong under the others. Writes to a single lane and to both lanes separate the two byte enables. Odd and even byte accesses through the data port separate the two pointer-increment rules. The straps are flipped after reset to show that the layout does not change, and the FIFO is filled past full to show that the extra push is ignored. The order of the words popped from the FIFO confirms they are held first in, first out.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;
  typedef enum logic [1:0] {ACC_IDLE, ACC_BUSY, ACC_DONE} acc_state_e;
  typedef enum logic [1:0] {TGT_NONE, TGT_REG, TGT_PTR} tgt_e;
endpackage

// File: rtl/hostbus_access.sv
module hostbus_access #(
  parameter int ACC_LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  input  logic strobe_i,
  output logic wait_o,
  output logic commit_o
);
  import hostbus_pkg::*;
  localparam int CW = (ACC_LAT > 1) ? $clog2(ACC_LAT) : 1;

  acc_state_e     state_q;
  logic [CW-1:0]  cnt_q;
  logic           wait_q;
  logic           commit_q;
  logic           req;

  assign req = sel_i && strobe_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ACC_IDLE;
      cnt_q    <= '0;
      wait_q   <= 1'b1;
      commit_q <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      case (state_q)
        ACC_IDLE: if (req) begin
          state_q <= ACC_BUSY;
          cnt_q   <= CW'(ACC_LAT - 1);
          wait_q  <= 1'b0;
        end
        ACC_BUSY: if (cnt_q == '0) begin
          state_q  <= ACC_DONE;
          wait_q   <= 1'b1;
          commit_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        ACC_DONE: if (!req) state_q <= ACC_IDLE;
        default: state_q <= ACC_IDLE;
      endcase
    end
  end

  assign wait_o   = wait_q;
  assign commit_o = commit_q;

  assert_wait_fall_needs_access_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(wait_q) |-> $past(req));
  assert_commit_with_wait_high_R3: assert property (@(posedge clk) disable iff (rst)
    commit_q |-> wait_q);
  assert_single_commit_R3: assert property (@(posedge clk) disable iff (rst)
    commit_q |=> !commit_q);
endmodule

// File: rtl/hostbus_cmdfifo.sv
module hostbus_cmdfifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          req_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q, count_nxt;
  logic          req_q, do_push, do_pop;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_comb begin
    count_nxt = count_q;
    if (do_push && !do_pop) count_nxt = count_q + 1'b1;
    if (do_pop && !do_push) count_nxt = count_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      req_q    <= 1'b0;
    end else begin
      if (do_push) wr_ptr_q <= AW'((32'(wr_ptr_q) + 1) % DEPTH);
      if (do_pop)  rd_ptr_q <= AW'((32'(rd_ptr_q) + 1) % DEPTH);
      count_q <= count_nxt;
      req_q   <= push_i ? 1'b0 : (count_nxt != CW'(DEPTH));
    end
  end

  assign data_o  = mem[rd_ptr_q];
  assign valid_o = !empty_o;
  assign req_o   = req_q;

  assert_req_drops_after_push_R11: assert property (@(posedge clk) disable iff (rst)
    push_i |=> !req_q);
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));
  assert_full_push_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (full_o && push_i && !pop_i) |=> (count_q == $past(count_q)));
endmodule

// File: rtl/hostbus_irq.sv
module hostbus_irq #(
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] status_i,
  input  logic [SW-1:0] enable_i,
  input  logic          clr_i,
  output logic          irq_o
);
  logic match, match_q, irq_q;

  assign match = |(status_i & enable_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      match_q <= match;
      if (clr_i)                 irq_q <= 1'b0;
      else if (match && !match_q) irq_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;

  assert_clear_on_access_R10: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !irq_q);
  assert_set_only_on_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(match && !match_q));
endmodule

// File: rtl/hostbus_regif.sv
module hostbus_regif #(
  parameter int          AW         = 7,
  parameter int          DW         = 16,
  parameter int          NREGS      = 64,
  parameter int          ACC_LAT    = 3,
  parameter int          FIFO_DEPTH = 4,
  parameter logic [15:0] CTRL_RST   = 16'h0C01
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          width16_strap_i,
  input  logic          indirect_strap_i,
  input  logic          sel_i,
  input  logic          rd_i,
  input  logic          wr_hi_i,
  input  logic          wr_lo_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          wait_o,
  output logic          wait_oe_o,
  output logic          irq_od_oe_o,
  output logic          irq_pp_n_o,
  output logic          dma_req_o,
  input  logic          dma_ack_i,
  input  logic          cmd_pop_i,
  output logic [DW-1:0] cmd_data_o,
  output logic          cmd_valid_o
);
  import hostbus_pkg::*;
  localparam int IW   = $clog2(NREGS);
  localparam int HALF = DW / 2;

  logic          mode_w16_q, mode_ind_q;
  logic [IW-1:0] ptr_q;
  logic [DW-1:0] regs [NREGS];
  logic [DW-1:0] rdata_q, wd, rv;
  logic [1:0]    be;
  logic [IW-1:0] idx;
  tgt_e          tgt;
  logic          any_wr, commit, fifo_full, fifo_empty, irq;

  // Straps captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_w16_q <= width16_strap_i;
      mode_ind_q <= indirect_strap_i;
    end
  end

  assign any_wr = wr_hi_i || wr_lo_i;

  hostbus_access #(.ACC_LAT(ACC_LAT)) acc_i (
    .clk(clk), .rst(rst), .sel_i(sel_i), .strobe_i(rd_i || any_wr),
    .wait_o(wait_o), .commit_o(commit));

  assign wait_oe_o = sel_i;

  // Address decode
  always_comb begin
    tgt = TGT_NONE;
    idx = '0;
    if (!mode_ind_q) begin
      tgt = TGT_REG;
      idx = IW'(addr_i[AW-1:1]);
    end else if (addr_i[3:1] == 3'd0) begin
      tgt = TGT_PTR;
    end else if (addr_i[3:1] == 3'd1) begin
      tgt = TGT_REG;
      idx = ptr_q;
    end
  end

  // Lane steering
  always_comb begin
    if (mode_w16_q) begin
      be = {wr_hi_i, wr_lo_i};
      wd = wdata_i;
    end else begin
      be = any_wr ? (addr_i[0] ? 2'b10 : 2'b01) : 2'b00;
      wd = {wdata_i[HALF-1:0], wdata_i[HALF-1:0]};
    end
  end

  always_comb begin
    case (tgt)
      TGT_REG: rv = regs[idx];
      TGT_PTR: rv = {{(DW-IW){1'b0}}, ptr_q};
      default: rv = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= (i == 0) ? DW'(CTRL_RST) : '0;
      ptr_q   <= '0;
      rdata_q <= '0;
    end else if (commit) begin
      if (tgt == TGT_REG) begin
        if (be[1]) regs[idx][DW-1:HALF] <= wd[DW-1:HALF];
        if (be[0]) regs[idx][HALF-1:0]  <= wd[HALF-1:0];
      end
      if (tgt == TGT_PTR && be[0]) ptr_q <= wd[IW-1:0];
      else if (tgt == TGT_REG && mode_ind_q && (mode_w16_q || addr_i[0])) ptr_q <= ptr_q + 1'b1;
      if (rd_i) rdata_q <= mode_w16_q ? rv
                          : {{HALF{1'b0}}, (addr_i[0] ? rv[DW-1:HALF] : rv[HALF-1:0])};
    end
  end

  assign rdata_o = rdata_q;

  hostbus_cmdfifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .push_i(dma_ack_i && any_wr && !sel_i), .data_i(wdata_i),
    .pop_i(cmd_pop_i), .data_o(cmd_data_o), .valid_o(cmd_valid_o),
    .full_o(fifo_full), .empty_o(fifo_empty), .req_o(dma_req_o));

  hostbus_irq #(.SW(2)) irq_i (
    .clk(clk), .rst(rst), .status_i({fifo_full, fifo_empty}), .enable_i(regs[1][1:0]),
    .clr_i(commit), .irq_o(irq));

  assign irq_od_oe_o = irq;
  assign irq_pp_n_o  = ~irq;

  assert_straps_frozen_R12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(mode_w16_q) && $stable(mode_ind_q)));
  assert_ptr_steps_by_one_R7: assert property (@(posedge clk) disable iff (rst)
    (commit && tgt == TGT_REG && mode_ind_q && mode_w16_q) |=> (ptr_q == $past(ptr_q) + 1'b1));
endmodule

// File: tb/hostbus_regif_tb_top.sv
module hostbus_regif_tb_top;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic w16_strap = 1'b1, ind_strap = 1'b0;
  logic sel = 1'b0, rd = 1'b0, whi = 1'b0, wlo = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, cmd_data;
  logic wait_l, wait_oe, irq_oe, irq_n, dreq, dack = 1'b0, cpop = 1'b0, cvalid;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  bit mon_go = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  hostbus_regif #(.ACC_LAT(LAT)) dut_i (
    .clk(clk), .rst(rst), .width16_strap_i(w16_strap), .indirect_strap_i(ind_strap),
    .sel_i(sel), .rd_i(rd), .wr_hi_i(whi), .wr_lo_i(wlo), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .wait_o(wait_l), .wait_oe_o(wait_oe), .irq_od_oe_o(irq_oe),
    .irq_pp_n_o(irq_n), .dma_req_o(dreq), .dma_ack_i(dack), .cmd_pop_i(cpop),
    .cmd_data_o(cmd_data), .cmd_valid_o(cvalid));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data from the scoreboard queue
  initial begin
    forever begin
      wait (mon_go);
      if (exp_q.size() == 0) chk("scoreboard empty", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), {16'h0, rdata}, {16'h0, exp_q.pop_front()});
      mon_go = 1'b0;
    end
  end

  task automatic access(input logic r, input logic h, input logic l,
                        input logic [6:0] a, input logic [15:0] d);
    int low;
    @(negedge clk);
    sel = 1'b1; addr = a; wdata = d; rd = r; whi = h; wlo = l;
    low = 0;
    @(negedge clk);
    while (wait_l == 1'b0) begin low++; @(negedge clk); end
    chk("R3 wait low cycles", low, LAT);
    chk("R3 wait oe during access", {31'h0, wait_oe}, 32'd1);
    @(negedge clk);
    chk("R3 wait held high until strobes drop", {31'h0, wait_l}, 32'd1);
    if (r) begin mon_go = 1'b1; wait (!mon_go); end
    sel = 1'b0; rd = 1'b0; whi = 1'b0; wlo = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [6:0] a, input logic [15:0] d, input logic h, input logic l);
    access(1'b0, h, l, a, d);
  endtask

  task automatic bus_rd(input logic [6:0] a, input logic [15:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    access(1'b1, 1'b0, 1'b0, a, 16'h0);
  endtask

  task automatic dma_push(input logic [15:0] d);
    @(negedge clk);
    dack = 1'b1; wlo = 1'b1; wdata = d;
    @(negedge clk);
    dack = 1'b0; wlo = 1'b0;
    chk("R11 request low after push", {31'h0, dreq}, 32'd0);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic w, input logic i);
    @(negedge clk);
    rst = 1'b1; w16_strap = w; ind_strap = i;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic irq_chk(input string tag, input logic e);
    chk(tag, {31'h0, irq_oe}, {31'h0, e});
    chk("R10 push-pull copy matches", {31'h0, irq_n}, {31'h0, ~e});
  endtask

  initial begin
    // 16-bit flat layout
    do_reset(1'b1, 1'b0);
    chk("R1 wait pad off when unselected", {31'h0, wait_oe}, 32'd0);
    chk("R11 request after reset", {31'h0, dreq}, 32'd1);
    irq_chk("R9 no interrupt after reset", 1'b0);
    @(negedge clk); sel = 1'b1;
    @(negedge clk);
    chk("R2 selected idle oe", {31'h0, wait_oe}, 32'd1);
    chk("R2 selected idle level", {31'h0, wait_l}, 32'd1);
    sel = 1'b0;
    bus_rd(7'd0,  16'h0C01, "R8 register 0 reset value");
    bus_rd(7'd10, 16'h0000, "R8 register 5 reset value");
    bus_wr(7'd10, 16'hBEEF, 1'b1, 1'b1);
    bus_rd(7'd10, 16'hBEEF, "R4 both lanes");
    bus_wr(7'd10, 16'h1200, 1'b1, 1'b0);
    bus_rd(7'd10, 16'h12EF, "R4 upper lane only");
    bus_wr(7'd10, 16'h0034, 1'b0, 1'b1);
    bus_rd(7'd10, 16'h1234, "R4 lower lane only");
    bus_wr(7'd126, 16'hA5A5, 1'b1, 1'b1);
    bus_rd(7'd126, 16'hA5A5, "R4 last word");
    w16_strap = 1'b0; ind_strap = 1'b1;
    bus_rd(7'd10, 16'h1234, "R12 straps ignored after reset");

    // 8-bit window layout
    do_reset(1'b0, 1'b1);
    bus_wr(7'd0, 16'h0005, 1'b0, 1'b1);
    bus_wr(7'd2, 16'h0011, 1'b0, 1'b1);
    bus_rd(7'd0, 16'h0005, "R7 no step after lower byte");
    bus_wr(7'd3, 16'h0022, 1'b0, 1'b1);
    bus_rd(7'd0, 16'h0006, "R7 step after upper byte");
    bus_wr(7'd0, 16'h0005, 1'b0, 1'b1);
    bus_rd(7'd2, 16'h0011, "R5 lower byte via port");
    bus_rd(7'd3, 16'h0022, "R5 upper byte via port");
    bus_wr(7'd8, 16'h0077, 1'b0, 1'b1);
    bus_rd(7'd8, 16'h0000, "R6 unmapped window word");
    bus_wr(7'd0, 16'h0000, 1'b0, 1'b1);
    bus_rd(7'd3, 16'h000C, "R8 register 0 upper byte");
    // interrupt: enable FIFO-empty
    bus_wr(7'd0, 16'h0001, 1'b0, 1'b1);
    bus_wr(7'd2, 16'h0001, 1'b0, 1'b1);
    irq_chk("R9 interrupt on empty enabled", 1'b1);
    bus_rd(7'd0, 16'h0001, "R6 pointer read");
    irq_chk("R10 cleared by access", 1'b0);
    bus_wr(7'd2, 16'h0002, 1'b0, 1'b1);
    irq_chk("R9 no interrupt before full", 1'b0);
    dma_push(16'h1111); dma_push(16'h2222); dma_push(16'h3333); dma_push(16'h4444);
    chk("R11 no request while full", {31'h0, dreq}, 32'd0);
    irq_chk("R9 interrupt on full", 1'b1);
    dma_push(16'h5555);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R11 FIFO order", {16'h0, cmd_data}, 32'h1111 * (k + 1));
      cpop = 1'b1;
      @(negedge clk);
      cpop = 1'b0;
    end
    @(negedge clk);
    chk("R11 push into full ignored", {31'h0, cvalid}, 32'd0);
    chk("R11 request back with space", {31'h0, dreq}, 32'd1);

    // 16-bit window layout
    do_reset(1'b1, 1'b1);
    bus_wr(7'd0, 16'h0002, 1'b1, 1'b1);
    bus_wr(7'd2, 16'hCAFE, 1'b1, 1'b1);
    bus_wr(7'd2, 16'hF00D, 1'b1, 1'b1);
    bus_rd(7'd0, 16'h0004, "R7 step per word access");
    bus_wr(7'd0, 16'h0002, 1'b1, 1'b1);
    bus_rd(7'd2, 16'hCAFE, "R6 data port first");
    bus_rd(7'd2, 16'hF00D, "R6 data port second");

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule